// File: doc/BRIEF.md
# Floating-Point Period Audio Oscillator

This block produces one oscillator voice as a stream of signed waveform samples. Pitch comes from a 13-bit period word in a small floating-point form. The top four bits are an exponent that picks one bit of an externally supplied octave enable vector. The low nine bits are a mantissa that gives the period length in enabled updates. An update happens only on a sample tick that coincides with the selected enable bit. Each update subtracts a fixed power of two from a phase counter. When that subtraction would go below zero, the mantissa is added back instead, and a small sawtooth counter advances by one. Because the counter works in whole steps, the period is always a whole number of samples. Raising the exponent by one halves the update rate, which lowers the pitch by one octave.

A two-bit waveform select shapes the output from the sawtooth state. The choices are a narrow pulse, a square wave, noise from a 16-bit shift register that steps on every sawtooth wrap, or the sawtooth itself. The exponent value 15 switches the voice off. A two-state controller tracks whether the voice is sounding. `ST_OFF` is entered at reset and whenever the exponent is 15; in this state the output is zero and all counters keep their values. The controller moves from `ST_OFF` to `ST_RUN` on the first enabled update (transition T_START). It moves from `ST_RUN` back to `ST_OFF` on the first clock that sees exponent 15 (transition T_STOP).

Top module: `osc_fp_voice`

## Requirements
- R1: After reset the output is zero, the controller is in `ST_OFF`, the phase and sawtooth counters are zero, and the noise register holds 16'h0001.
- R2: The period word splits into `period[12:9]` as the exponent E and `period[8:0]` as the mantissa M. State advances only on a clock where `sample_tick` is high and `oct_en[E]` is high.
- R3: While E is 15 no update happens. From the next clock on, the output is zero, and the phase counter, the sawtooth and the noise register keep their values.
- R4: Each update works on the phase counter C. If C is at least 2^SAW_W, C becomes C - 2^SAW_W. Otherwise C becomes C + M - 2^SAW_W and the sawtooth S advances by one modulo 2^SAW_W. With M of at least 2^SAW_W, S therefore wraps once every M updates.
- R5: With select 3 (saw), the output is S - 2^(SAW_W-1) as a two's-complement value.
- R6: With select 1 (square), the output is +(2^(SAW_W-1)-1) when the MSB of S is 1, and -2^(SAW_W-1) when it is 0.
- R7: With select 0 (pulse), the output is the positive level while S is below 2^(SAW_W-2), and the negative level otherwise.
- R8: With select 2 (noise), the output is the positive level when bit 0 of the noise register is 1, and the negative level otherwise. On every update where S wraps from all ones to zero, the register shifts left and takes bit15^bit13^bit12^bit10 into bit 0.
- R9: The waveform select acts combinationally. Changing it alters the output in the same cycle and changes no counter.
- R10: After reset, or after `ST_OFF` was entered, the output stays zero until the first enabled update (T_START). From that update on, the shaped waveform appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-clock sample strobe, nominally once every 32 clocks |
| oct_en | input | 15 | Octave enables; bit i is high on one tick in every 2^i |
| period | input | 13 | Exponent in [12:9], mantissa in [8:0] |
| wave_sel | input | 2 | 0 pulse, 1 square, 2 noise, 3 saw |
| wave_o | output | 5 | Signed waveform sample |

## Verification
The hardest state to reach from the ports is a long noise sequence. The noise register moves only on a sawtooth wrap, which takes M times 2^E ticks per step. The bench therefore spends its longest runs at exponent 0 with the smallest legal mantissa, so the register steps many times. At every tick it compares all four waveform selects against an arithmetic model of the counter, the sawtooth and the shift register. The bench also parks the voice at exponent 15 partway through the sequence and then resumes. This shows at the ports that no state moved while the voice was off, because the resumed waveform must continue exactly where the model left it.

// File: rtl/osc_fp_pkg.sv
package osc_fp_pkg;

    localparam int NOISE_W = 16;
    localparam logic [NOISE_W-1:0] NOISE_SEED = 16'h0001;

    typedef enum logic [1:0] {
        WAVE_PULSE  = 2'd0,
        WAVE_SQUARE = 2'd1,
        WAVE_NOISE  = 2'd2,
        WAVE_SAW    = 2'd3
    } wave_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } osc_state_e;

endpackage

// File: rtl/osc_phase_cnt.sv
module osc_phase_cnt #(
    parameter int MANT_W = 9,
    parameter int SAW_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [MANT_W-1:0] mant_i,
    output logic [SAW_W-1:0]  saw_o,
    output logic [MANT_W-1:0] cnt_o,
    output logic              wrap_o
);
    localparam int STEP_I = 1 << SAW_W;
    localparam logic [MANT_W:0] STEP = STEP_I[MANT_W:0];

    logic [MANT_W-1:0] cnt_q, cnt_d;
    logic [SAW_W-1:0]  saw_q;
    logic [MANT_W:0]   sum;
    logic              reload;

    always_comb begin
        reload = ({1'b0, cnt_q} < STEP);
        sum    = {1'b0, cnt_q} + {1'b0, mant_i} - STEP;
        cnt_d  = reload ? sum[MANT_W-1:0] : (cnt_q - STEP[MANT_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            saw_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_d;
            if (reload) begin
                saw_q <= saw_q + 1'b1;
            end
        end
    end

    assign wrap_o = step_i & reload & (&saw_q);
    assign saw_o  = saw_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/osc_noise_lfsr.sv
module osc_noise_lfsr
    import osc_fp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    output logic [NOISE_W-1:0] state_o,
    output logic               bit_o
);
    logic [NOISE_W-1:0] lfsr_q;
    logic               fb;

    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= NOISE_SEED;
        end else if (step_i) begin
            lfsr_q <= {lfsr_q[NOISE_W-2:0], fb};
        end
    end

    assign state_o = lfsr_q;
    assign bit_o   = lfsr_q[0];
endmodule

// File: rtl/osc_wave_shape.sv
module osc_wave_shape
    import osc_fp_pkg::*;
#(
    parameter int SAW_W = 5
) (
    input  wave_e                   sel_i,
    input  logic [SAW_W-1:0]        saw_i,
    input  logic                    noise_i,
    output logic signed [SAW_W-1:0] wave_o
);
    localparam logic [SAW_W-1:0] LVL_HI = {1'b0, {(SAW_W-1){1'b1}}};
    localparam logic [SAW_W-1:0] LVL_LO = {1'b1, {(SAW_W-1){1'b0}}};

    logic [SAW_W-1:0] shaped;

    always_comb begin
        unique case (sel_i)
            WAVE_PULSE:  shaped = (saw_i[SAW_W-1:SAW_W-2] == 2'b00) ? LVL_HI : LVL_LO;
            WAVE_SQUARE: shaped = saw_i[SAW_W-1] ? LVL_HI : LVL_LO;
            WAVE_NOISE:  shaped = noise_i ? LVL_HI : LVL_LO;
            WAVE_SAW:    shaped = {~saw_i[SAW_W-1], saw_i[SAW_W-2:0]};
            default:     shaped = '0;
        endcase
    end

    assign wave_o = $signed(shaped);
endmodule

// File: rtl/osc_fp_voice.sv
module osc_fp_voice
    import osc_fp_pkg::*;
#(
    parameter int EXP_W  = 4,
    parameter int MANT_W = 9,
    parameter int SAW_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_tick,
    input  logic [(1<<EXP_W)-2:0]         oct_en,
    input  logic [EXP_W+MANT_W-1:0]       period,
    input  logic [1:0]                    wave_sel,
    output logic signed [SAW_W-1:0]       wave_o
);
    localparam int PER_W  = EXP_W + MANT_W;
    localparam int NUM_EN = 1 << EXP_W;

    logic [EXP_W-1:0]   exp_f;
    logic [MANT_W-1:0]  mant_f;
    logic [NUM_EN-1:0]  oct_pad;
    logic               exp_off;
    logic               step;

    osc_state_e         state_q, state_d;
    logic [SAW_W-1:0]   saw_q;
    logic [MANT_W-1:0]  cnt_q;
    logic               wrap;
    logic [NOISE_W-1:0] lfsr_q;
    logic               noise_bit;
    logic signed [SAW_W-1:0] shaped;

    assign exp_f   = period[PER_W-1:MANT_W];
    assign mant_f  = period[MANT_W-1:0];
    assign exp_off = &exp_f;
    assign oct_pad = {1'b0, oct_en};
    assign step    = sample_tick & ~exp_off & oct_pad[exp_f];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (step)    state_d = ST_RUN;
            ST_RUN: if (exp_off) state_d = ST_OFF;
            default:             state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    osc_phase_cnt #(.MANT_W(MANT_W), .SAW_W(SAW_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .mant_i (mant_f),
        .saw_o  (saw_q),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    osc_noise_lfsr u_noise (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (wrap),
        .state_o (lfsr_q),
        .bit_o   (noise_bit)
    );

    osc_wave_shape #(.SAW_W(SAW_W)) u_shape (
        .sel_i   (wave_e'(wave_sel)),
        .saw_i   (saw_q),
        .noise_i (noise_bit),
        .wave_o  (shaped)
    );

    always_comb begin
        unique case (state_q)
            ST_RUN:  wave_o = shaped;
            default: wave_o = '0;
        endcase
    end
endmodule

// File: rtl/osc_fp_voice_chk.sv
module osc_fp_voice_chk
    import osc_fp_pkg::*;
#(
    parameter int EXP_W  = 4,
    parameter int MANT_W = 9,
    parameter int SAW_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_tick,
    input logic [EXP_W+MANT_W-1:0] period,
    input logic signed [SAW_W-1:0] wave_o,
    input logic [SAW_W-1:0]        saw_q,
    input logic [MANT_W-1:0]       cnt_q,
    input logic [NOISE_W-1:0]      lfsr_q
);
    logic exp_off;
    assign exp_off = &period[EXP_W+MANT_W-1:MANT_W];

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        exp_off |=> (wave_o == '0)); // R3

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        exp_off |=> ($stable(saw_q) && $stable(cnt_q) && $stable(lfsr_q))); // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> ($stable(saw_q) && $stable(cnt_q) && $stable(lfsr_q))); // R2

    AST_SAW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (saw_q != $past(saw_q)) |-> (saw_q == $past(saw_q) + 1'b1)); // R4

    AST_NOISE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_q != $past(lfsr_q)) |-> ((saw_q == '0) && (&$past(saw_q)))); // R8
endmodule

bind osc_fp_voice osc_fp_voice_chk #(
    .EXP_W  (EXP_W),
    .MANT_W (MANT_W),
    .SAW_W  (SAW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .period      (period),
    .wave_o      (wave_o),
    .saw_q       (saw_q),
    .cnt_q       (cnt_q),
    .lfsr_q      (lfsr_q)
);

// File: tb/osc_fp_voice_tb.sv
`timescale 1ns/1ps
module osc_fp_voice_tb;
    localparam int SAW_W = 5;
    localparam int STEPV = 1 << SAW_W;
    localparam int TICK_GAP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_tick = 1'b0;
    logic [14:0] oct_en = '0;
    logic [12:0] period = '1;
    logic [1:0]  wave_sel = 2'd0;
    logic signed [SAW_W-1:0] wave_o;

    int vectors = 0;
    int misses = 0;
    int octcnt = 1;
    bit m_on = 0;
    int m_cnt = 0;
    int m_saw = 0;
    logic [15:0] m_lfsr = 16'h0001;
    bit finished = 0;

    always #2 clk = ~clk;

    osc_fp_voice u_dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .oct_en(oct_en),
        .period(period), .wave_sel(wave_sel), .wave_o(wave_o)
    );

    function automatic int expect_wave(int ws);
        int hi = (STEPV/2) - 1;
        int lo = -(STEPV/2);
        if (!m_on) return 0;
        case (ws)
            0: return (m_saw < STEPV/4) ? hi : lo;        // R7
            1: return (m_saw >= STEPV/2) ? hi : lo;       // R6
            2: return m_lfsr[0] ? hi : lo;                // R8
            default: return m_saw - STEPV/2;              // R5
        endcase
    endfunction

    function automatic string req_of(int ws);
        case (ws)
            0: return "R7";
            1: return "R6";
            2: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic check_all(string ctx);
        for (int ws = 0; ws < 4; ws++) begin
            int exp_v;
            wave_sel = ws[1:0];
            #0.1;
            exp_v = expect_wave(ws);
            vectors++;
            if (int'(wave_o) != exp_v) begin
                misses++;
                $display("FAIL %s/%s/R9 sel=%0d actual=%0d expected=%0d", req_of(ws), ctx, ws, wave_o, exp_v);
            end
        end
    endtask

    task automatic model_step();
        int e = int'(period[12:9]);
        int m = int'(period[8:0]);
        if (e != 15 && (octcnt % (1 << e)) == 0) begin
            m_on = 1;
            if (m_cnt >= STEPV) begin
                m_cnt = m_cnt - STEPV;
            end else begin
                m_cnt = m_cnt + m - STEPV;
                if (m_saw == STEPV - 1) begin
                    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
                end
                m_saw = (m_saw + 1) % STEPV;
            end
        end
    endtask

    task automatic tick_once(string ctx);
        @(negedge clk);
        sample_tick = 1'b1;
        for (int i = 0; i < 15; i++) oct_en[i] = ((octcnt % (1 << i)) == 0);
        @(negedge clk);
        sample_tick = 1'b0;
        oct_en = '0;
        model_step();
        octcnt++;
        check_all(ctx);
        repeat (TICK_GAP - 2) @(negedge clk);
    endtask

    task automatic set_period(int e, int m);
        @(negedge clk);
        period = {e[3:0], m[8:0]};
        if (e == 15) m_on = 0;
    endtask

    task automatic run(int e, int m, int n, string ctx);
        set_period(e, m);
        for (int k = 0; k < n; k++) tick_once(ctx);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");                 // R1 reset: silent
        run(3, 40, 4, "R10");            // R10 no enabled update yet: still zero
        run(3, 40, 200, "R2");           // R2 exponent gating
        run(0, 32, 600, "R4");           // R4 shortest period, many noise steps
        run(0, 37, 300, "R4");
        run(1, 33, 200, "R2");
        run(15, 40, 60, "R3");           // R3 parked: output zero, state held
        run(0, 45, 200, "R3");           // resume must continue held state
        run(2, 100, 150, "R2");
        run(0, 511, 100, "R4");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule